// File: doc/BRIEF.md
# Stripe-Ordered 3x3 Window Generator

This block turns a pixel stream into 3x3 neighbourhoods for a downstream filter. The stream does not arrive as full-width image rows. The image is cut into vertical stripes of `STRIPE_W` columns, and the stripes are sent one after another from left to right. Inside a stripe, pixels come row by row, top to bottom. Because of this, the two stored rows only need to be as deep as one stripe plus two columns, not as deep as the whole image. Adding more stripes makes that storage smaller, and the rate stays at one pixel per cycle.

A window that sits on a stripe edge needs a column from the neighbouring stripe. So the upstream fetcher sends those neighbour columns again:
- Every stripe except the first starts with one extra column from its left neighbour.
- Every stripe except the last ends with one extra column from its right neighbour.

The last stripe may be narrower than the others. The block keeps count of stripe, row and column in the stripe. It emits a window, with the image-space coordinates of the window centre, only when the centre is a core column of the current stripe and lies inside the image border. Each interior pixel of a frame is therefore emitted exactly once. After the last pixel of the last stripe, the next pixel starts a new frame.

Top module: `stripe_win3_top`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 until a window is complete.
- R2: A pixel is taken only in a cycle with `in_valid` = 1. Idle cycles do not move the column, row or stripe position, and produce no window.
- R3: Stripe s (from 0) has core columns s*STRIPE_W up to min((s+1)*STRIPE_W, IMG_W)-1. Its fetched row is the core, plus one column on the left when s>0, plus one column on the right when s is not the last stripe. The last stripe may be narrower than the others.
- R4: `out_win` element k = 3*r + c, at bits [k*PIX_W +: PIX_W], holds the image pixel at row `out_y`-1+r and column `out_x`-1+c.
- R5: `out_x` and `out_y` give the window centre in full-image coordinates.
- R6: A window is emitted only when its centre is a core column of the current stripe and satisfies 1 <= x <= IMG_W-2 and 1 <= y <= IMG_H-2. Windows centred on refetched columns or on the image border are never emitted. Every interior pixel is emitted exactly once per frame.
- R7: `out_valid` rises in the cycle after the window's bottom-right pixel is accepted.
- R8: After the last pixel of the last stripe, the next pixel is treated as row 0, column 0 of stripe 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is present on `in_pix` this cycle |
| in_pix | input | PIX_W | Pixel value, in stripe order |
| out_valid | output | 1 | The window outputs are valid this cycle |
| out_x | output | $clog2(IMG_W) | Image column of the window centre |
| out_y | output | $clog2(IMG_H) | Image row of the window centre |
| out_win | output | 9*PIX_W | 3x3 window, row-major, top-left element first |

## Verification
The bench streams three frames. Each frame uses its own pixel function of position and frame number, so an element taken from the wrong row, column or frame shows up as a value mismatch.

- The first frame runs with `in_valid` high on every cycle. This shows the basic shift and store order.
- The second frame has idle cycles placed at scattered points, including at row and stripe ends. This separates a design that counts cycles from one that counts accepted pixels.
- The third frame follows the second without a reset. This shows the stripe and frame wrap.

Windows next to stripe edges check that refetched columns are used as neighbours but never as centres. The narrow last stripe checks the per-stripe widths.

// File: rtl/stripe_win3_pkg.sv
package stripe_win3_pkg;

    // number of core (owned) columns in stripe s
    function automatic int core_cols(input int s, input int img_w, input int sw);
        int rem;
        rem = img_w - s * sw;
        return (rem < sw) ? rem : sw;
    endfunction

    // columns actually streamed for stripe s, overlap included
    function automatic int fetch_cols(input int s, input int img_w, input int sw, input int ns);
        return core_cols(s, img_w, sw) + ((s > 0) ? 1 : 0) + ((s < ns - 1) ? 1 : 0);
    endfunction

    // image column of the first streamed column of stripe s
    function automatic int first_col(input int s, input int sw);
        return s * sw - ((s > 0) ? 1 : 0);
    endfunction

endpackage

// File: rtl/stripe_win3_seq.sv
module stripe_win3_seq
    import stripe_win3_pkg::*;
#(
    parameter int IMG_W = 20,
    parameter int IMG_H = 6,
    parameter int STRIPE_W = 8,
    parameter int NS = 3,
    parameter int SBW = 2,
    parameter int CW = 4,
    parameter int XW = 5,
    parameter int YW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic [SBW-1:0] cur_stripe,
    output logic [CW-1:0]  cur_col,
    output logic [YW-1:0]  cur_row,
    output logic [XW-1:0]  cur_gx,
    output logic           ctr_ok
);
    typedef struct packed {
        logic [SBW-1:0] stripe;
        logic [YW-1:0]  row;
        logic [CW-1:0]  col;
    } pos_t;

    pos_t pos_d, pos_q;
    int   fw, gx, cx, cs, cw;

    always_comb begin
        pos_d = pos_q;
        fw = fetch_cols(int'(pos_q.stripe), IMG_W, STRIPE_W, NS);
        cs = int'(pos_q.stripe) * STRIPE_W;
        cw = core_cols(int'(pos_q.stripe), IMG_W, STRIPE_W);
        gx = first_col(int'(pos_q.stripe), STRIPE_W) + int'(pos_q.col);
        cx = gx - 1;
        if (in_valid) begin
            if (int'(pos_q.col) == fw - 1) begin
                pos_d.col = '0;
                if (int'(pos_q.row) == IMG_H - 1) begin
                    pos_d.row = '0;
                    pos_d.stripe = (int'(pos_q.stripe) == NS - 1) ? '0 : pos_q.stripe + 1'b1;
                end else begin
                    pos_d.row = pos_q.row + 1'b1;
                end
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
        ctr_ok = (int'(pos_q.row) >= 2) && (cx >= cs) && (cx < cs + cw)
                 && (cx >= 1) && (cx <= IMG_W - 2);
        cur_gx = XW'(gx);
    end

    assign cur_stripe = pos_q.stripe;
    assign cur_col    = pos_q.col;
    assign cur_row    = pos_q.row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R3
    col_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos_q.col) < fetch_cols(int'(pos_q.stripe), IMG_W, STRIPE_W, NS));
endmodule

// File: rtl/stripe_win3_linebuf.sv
module stripe_win3_linebuf #(
    parameter int PIX_W = 8,
    parameter int LB_D = 10,
    parameter int CW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    col,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] row_up1,
    output logic [PIX_W-1:0] row_up2
);
    typedef struct packed {
        logic [LB_D-1:0][PIX_W-1:0] up1;
        logic [LB_D-1:0][PIX_W-1:0] up2;
    } lb_t;

    lb_t lb_d, lb_q;

    always_comb begin
        lb_d = lb_q;
        row_up1 = lb_q.up1[col];
        row_up2 = lb_q.up2[col];
        if (wr_en) begin
            lb_d.up2[col] = lb_q.up1[col];
            lb_d.up1[col] = pix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lb_q <= '0;
        else        lb_q <= lb_d;
    end
endmodule

// File: rtl/stripe_win3_shift.sv
module stripe_win3_shift #(
    parameter int PIX_W = 8,
    parameter int XW = 5,
    parameter int YW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               emit,
    input  logic [PIX_W-1:0]   col_top,
    input  logic [PIX_W-1:0]   col_mid,
    input  logic [PIX_W-1:0]   col_bot,
    input  logic [XW-1:0]      ctr_x,
    input  logic [YW-1:0]      ctr_y,
    output logic               out_valid,
    output logic [XW-1:0]      out_x,
    output logic [YW-1:0]      out_y,
    output logic [9*PIX_W-1:0] out_win
);
    typedef struct packed {
        logic [2:0][2:0][PIX_W-1:0] w;
        logic                       vld;
        logic [XW-1:0]              x;
        logic [YW-1:0]              y;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        win_d.vld = shift_en && emit;
        if (shift_en) begin
            for (int r = 0; r < 3; r++) begin
                win_d.w[r][0] = win_q.w[r][1];
                win_d.w[r][1] = win_q.w[r][2];
            end
            win_d.w[0][2] = col_top;
            win_d.w[1][2] = col_mid;
            win_d.w[2][2] = col_bot;
            win_d.x = ctr_x;
            win_d.y = ctr_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign out_valid = win_q.vld;
    assign out_x     = win_q.x;
    assign out_y     = win_q.y;
    assign out_win   = win_q.w;

    // R4
    win_slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.vld && $past(win_q.vld)) |->
            (win_q.w[0][0] == $past(win_q.w[0][1]) && win_q.w[1][1] == $past(win_q.w[1][2])
             && win_q.w[2][0] == $past(win_q.w[2][1])));
endmodule

// File: rtl/stripe_win3_top.sv
module stripe_win3_top
    import stripe_win3_pkg::*;
#(
    parameter int IMG_W = 20,
    parameter int IMG_H = 6,
    parameter int STRIPE_W = 8,
    parameter int PIX_W = 8,
    localparam int NS = (IMG_W + STRIPE_W - 1) / STRIPE_W,
    localparam int LB_D = STRIPE_W + 2,
    localparam int CW = $clog2(LB_D),
    localparam int XW = $clog2(IMG_W),
    localparam int YW = $clog2(IMG_H),
    localparam int SBW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               out_valid,
    output logic [XW-1:0]      out_x,
    output logic [YW-1:0]      out_y,
    output logic [9*PIX_W-1:0] out_win
);
    logic [SBW-1:0]   stripe;
    logic [CW-1:0]    col;
    logic [YW-1:0]    row;
    logic [XW-1:0]    gx;
    logic             ctr_ok;
    logic [PIX_W-1:0] up1, up2;

    stripe_win3_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H), .STRIPE_W(STRIPE_W), .NS(NS),
                      .SBW(SBW), .CW(CW), .XW(XW), .YW(YW)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_stripe(stripe),
        .cur_col(col), .cur_row(row), .cur_gx(gx), .ctr_ok(ctr_ok));

    stripe_win3_linebuf #(.PIX_W(PIX_W), .LB_D(LB_D), .CW(CW)) lb_i (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .col(col), .pix(in_pix),
        .row_up1(up1), .row_up2(up2));

    stripe_win3_shift #(.PIX_W(PIX_W), .XW(XW), .YW(YW)) sh_i (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .emit(ctr_ok),
        .col_top(up2), .col_mid(up1), .col_bot(in_pix),
        .ctr_x(gx - 1'b1), .ctr_y(row - 1'b1),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_win(out_win));

    // R6
    core_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_x) >= int'($past(stripe)) * STRIPE_W
                       && int'(out_x) < int'($past(stripe)) * STRIPE_W
                                        + core_cols(int'($past(stripe)), IMG_W, STRIPE_W)));
    // R6
    inside_border_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x >= 1 && int'(out_x) <= IMG_W - 2
                       && out_y >= 1 && int'(out_y) <= IMG_H - 2));
    // R7
    emit_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(col) && $stable(row) && $stable(stripe)));
endmodule

// File: tb/stripe_win3_tb_top.sv
`timescale 1ns/1ps
module stripe_win3_tb_top;
    localparam int W = 20, H = 6, SW = 8, PW = 8;
    localparam int NS = (W + SW - 1) / SW;
    localparam int XW = $clog2(W), YW = $clog2(H);

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [PW-1:0] in_pix = '0;
    logic out_valid;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [9*PW-1:0] out_win;

    int checks = 0, fails = 0, cycles = 0, win_seen = 0;
    bit drv_exp = 0, mon_en = 0, edge_win = 0;
    int drv_x = 0, drv_y = 0, drv_f = 0;

    always #10 clk = ~clk;

    stripe_win3_top #(.IMG_W(W), .IMG_H(H), .STRIPE_W(SW), .PIX_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_win(out_win));

    function automatic int pixf(int f, int x, int y);
        return (x * 37 + y * 11 + f * 91 + x * y) & 255;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model compared on every clock, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            if (in_valid && drv_exp) begin
                chk(out_valid == 1'b1, "R7 window missing", int'(out_valid), 1);
                if (out_valid) begin
                    win_seen++;
                    chk(int'(out_x) == drv_x, edge_win ? "R3/R5 x at stripe edge" : "R5 x",
                        int'(out_x), drv_x);
                    chk(int'(out_y) == drv_y, "R5 y", int'(out_y), drv_y);
                    for (int r = 0; r < 3; r++)
                        for (int c = 0; c < 3; c++)
                            chk(int'(out_win[(3*r+c)*PW +: PW]) == pixf(drv_f, drv_x-1+c, drv_y-1+r),
                                drv_f > 0 ? "R4/R8 window element" : "R4 window element",
                                int'(out_win[(3*r+c)*PW +: PW]), pixf(drv_f, drv_x-1+c, drv_y-1+r));
                end
            end else if (!in_valid) begin
                chk(out_valid == 1'b0, "R2 output on idle cycle", int'(out_valid), 0);
            end else begin
                chk(out_valid == 1'b0, "R6 unexpected window", int'(out_valid), 0);
            end
        end
    end

    task automatic run_frame(int f, bit gaps);
        for (int s = 0; s < NS; s++) begin
            int cs, cw, fl, fw;
            cs = s * SW;
            cw = (W - cs < SW) ? W - cs : SW;
            fl = (s > 0) ? 1 : 0;
            fw = cw + fl + ((s < NS - 1) ? 1 : 0);
            for (int y = 0; y < H; y++) begin
                for (int lc = 0; lc < fw; lc++) begin
                    int gx, cx;
                    gx = cs - fl + lc;
                    cx = gx - 1;
                    if (gaps && ((gx * 3 + y + s) % 4 == 0 || lc == fw - 1)) begin
                        @(negedge clk);
                        in_valid = 0;
                        drv_exp = 0;
                    end
                    @(negedge clk);
                    in_valid = 1;
                    in_pix = PW'(pixf(f, gx, y));
                    drv_exp = (y >= 2) && (cx >= cs) && (cx < cs + cw) && (cx >= 1) && (cx <= W - 2);
                    edge_win = (cx == cs) || (cx == cs + cw - 1);
                    drv_x = cx;
                    drv_y = y - 1;
                    drv_f = f;
                end
            end
        end
        @(negedge clk);
        in_valid = 0;
        drv_exp = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        mon_en = 1;
        run_frame(0, 0);
        @(negedge clk);
        chk(win_seen == (W - 2) * (H - 2), "R6 windows in frame 0", win_seen, (W - 2) * (H - 2));
        win_seen = 0;
        run_frame(1, 1);
        @(negedge clk);
        chk(win_seen == (W - 2) * (H - 2), "R2/R6 windows in gapped frame", win_seen, (W - 2) * (H - 2));
        win_seen = 0;
        run_frame(2, 0);
        @(negedge clk);
        chk(win_seen == (W - 2) * (H - 2), "R8 windows in wrapped frame", win_seen, (W - 2) * (H - 2));
        mon_en = 0;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule